// File: doc/BRIEF.md
# Immediate Control Command Mailbox

This block lets a host issue one control command at a time on a serial audio control channel and collect the reply. The host fills a 64-bit command as two 32-bit words through a small register port: the upper word is written first, and writing the lower word launches the command. The engine offers the packed command downstream on a valid/ready pair. Once the handshake completes, it waits for a single 64-bit response on a valid strobe. That response is latched into two readable response words, and a response-valid flag is raised in the status word.

Only one command may be outstanding. The host polls the busy flag before each launch. It consumes the response and then clears response-valid by writing a one to status bit 0, or by writing an all-zero word to the status offset. A launch attempted while a command is in flight, or while an unconsumed response still sits in the mailbox, is discarded and recorded in a sticky overrun flag.

The words pass through untouched, and the host packs them by convention. In the upper word, the tag flag is in bit 31, the opcode in bits 14:12 (read 2, write 3), the device number in bits 11:8, and the register address high byte in bits 7:0. In the lower word, the address low byte is in bits 31:24 and the write data in bits 14:7. An all-zero command is a ping. In a reply, bit 0 means ACK and bit 1 means NACK; when neither is set, the command was ignored. Read data sits in bits 14:7. A ping reply carries peripheral status for devices 0 to 3 in bits 14:7 and for devices 4 to 11 in bits 39:24.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the status word (offset 4) reads 0 and cmd_valid is low.
- R2: A write to offset 1 while idle and with no pending response drives cmd_valid high from the next cycle, with cmd_data = {word last written to offset 0, word written to offset 1}. Status bit 1 (busy) then reads 1.
- R3: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data stays unchanged. cmd_valid drops after the cycle in which cmd_ready is high.
- R4: A response strobe taken after the command handshake latches rsp_data. The upper half reads at offset 2 and the lower half at offset 3. In that same cycle, busy falls and status bit 0 (response-valid) rises.
- R5: A status write with bit 0 set, or an all-zero status write, clears response-valid. A nonzero status write with bit 0 clear leaves it unchanged.
- R6: A write to offset 1 while busy or while response-valid is set is dropped, and it sets sticky status bit 2 (overrun). Only a status write with bit 2 set clears that flag.
- R7: The response words keep their value after response-valid is cleared, until the next response is captured.
- R8: When a response capture and a response-valid clear fall in the same cycle, the capture wins and response-valid reads 1.
- R9: Writing offset 0 while a command is outstanding does not change cmd_data.
- R10: A response strobe while idle, or before the command handshake, is ignored: busy stays set and response-valid stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write offset (0 upper cmd, 1 lower cmd/launch, 4 status) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read offset (0 upper cmd, 2 upper rsp, 3 lower rsp, 4 status) |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_data | output | 64 | Packed command {upper, lower} |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | 64 | Response {upper, lower} |

## Verification
A response capture can land in the same clock edge as a host status write that clears response-valid. It can also land in the same edge as a host attempt to launch the next command. The bench provokes both collisions by raising rsp_valid on the very edge that carries the register write. For the first collision, it expects response-valid to read 1 afterwards. For the second, it expects no new command to be offered, the overrun flag to be set, and the captured response to be intact.

// File: rtl/cmdmb_pkg.sv
package cmdmb_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      OFS_CMD_HI = 3'd0,
      OFS_CMD_LO = 3'd1,
      OFS_RSP_HI = 3'd2,
      OFS_RSP_LO = 3'd3,
      OFS_STAT   = 3'd4
   } cmdmb_ofs_e;

   localparam int unsigned ST_RVALID = 0;
   localparam int unsigned ST_BUSY   = 1;
   localparam int unsigned ST_OVR    = 2;
   localparam int unsigned ST_W      = 3;
endpackage

// File: rtl/cmdmb_stage.sv
module cmdmb_stage #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] hi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hi_q <= '0;
      else if (load) hi_q <= din;
   end
endmodule

// File: rtl/cmdmb_issue.sv
module cmdmb_issue #(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned CMD_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_req,
   input  logic [WORD_W-1:0] lo_word,
   input  logic [WORD_W-1:0] hi_word,
   input  logic              rvalid_i,
   input  logic              clr_ovr,
   input  logic              cmd_ready,
   input  logic              rsp_valid,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_data,
   output logic              busy,
   output logic              take_rsp,
   output logic              overrun
);
   logic accept;

   always_comb begin
      accept   = launch_req & ~busy & ~rvalid_i;
      take_rsp = busy & ~cmd_valid & rsp_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_data  <= '0;
         overrun   <= 1'b0;
      end else begin
         if (accept) begin
            busy      <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_data  <= {hi_word, lo_word};
         end else begin
            if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
            if (take_rsp)               busy      <= 1'b0;
         end
         if (launch_req && !accept) overrun <= 1'b1;
         else if (clr_ovr)          overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/cmdmb_resp.sv
module cmdmb_resp #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NWORDS = 2,
   localparam int unsigned RSP_W = NWORDS * WORD_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          take,
   input  logic                          clr_rv,
   input  logic [RSP_W-1:0]              rsp_data,
   output logic [NWORDS-1:0][WORD_W-1:0] rsp_q,
   output logic                          rvalid
);
   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    rsp_q[w] <= '0;
         else if (take) rsp_q[w] <= rsp_data[w*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rvalid <= 1'b0;
      else if (take)   rvalid <= 1'b1;
      else if (clr_rv) rvalid <= 1'b0;
   end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import cmdmb_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned CMD_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [CMD_W-1:0]  cmd_data,
   input  logic              rsp_valid,
   input  logic [CMD_W-1:0]  rsp_data
);
   if (WORD_W < 16) begin : g_bad_width
      $error("cmd_mailbox: WORD_W must hold bit 14 fields");
   end

   logic                   wr_hi, wr_lo, wr_st, clr_rv, clr_ovr;
   logic [WORD_W-1:0]      hi_q;
   logic                   busy_w, take_w, ovr_w, rvalid_w;
   logic [1:0][WORD_W-1:0] rsp_q;
   logic [CMD_W-1:0]       rsp_flat;
   logic [ST_W-1:0]        stat;

   always_comb begin
      wr_hi   = reg_wr && (reg_addr == OFS_CMD_HI);
      wr_lo   = reg_wr && (reg_addr == OFS_CMD_LO);
      wr_st   = reg_wr && (reg_addr == OFS_STAT);
      clr_rv  = wr_st && (reg_wdata[ST_RVALID] || (reg_wdata == '0));
      clr_ovr = wr_st && reg_wdata[ST_OVR];
      rsp_flat = rsp_q;
      stat    = '0;
      stat[ST_RVALID] = rvalid_w;
      stat[ST_BUSY]   = busy_w;
      stat[ST_OVR]    = ovr_w;
   end

   cmdmb_stage #(.WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .load(wr_hi), .din(reg_wdata), .hi_q(hi_q)
   );

   cmdmb_issue #(.WORD_W(WORD_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .launch_req(wr_lo), .lo_word(reg_wdata),
      .hi_word(hi_q), .rvalid_i(rvalid_w), .clr_ovr(clr_ovr),
      .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .cmd_valid(cmd_valid),
      .cmd_data(cmd_data), .busy(busy_w), .take_rsp(take_w), .overrun(ovr_w)
   );

   cmdmb_resp #(.WORD_W(WORD_W), .NWORDS(2)) u_resp (
      .clk(clk), .rst_n(rst_n), .take(take_w), .clr_rv(clr_rv),
      .rsp_data(rsp_data), .rsp_q(rsp_q), .rvalid(rvalid_w)
   );

   always_comb begin
      case (reg_raddr)
         OFS_CMD_HI: reg_rdata = hi_q;
         OFS_RSP_HI: reg_rdata = rsp_q[1];
         OFS_RSP_LO: reg_rdata = rsp_q[0];
         OFS_STAT:   reg_rdata = {{(WORD_W-ST_W){1'b0}}, stat};
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmdmb_chk.sv
module cmdmb_chk #(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned CMD_W = 2 * WORD_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             rvalid,
   input logic             ovr,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [CMD_W-1:0] cmd_data,
   input logic [CMD_W-1:0] rsp_flat,
   input logic             reg_wr,
   input logic [2:0]       reg_addr,
   input logic             wdata_b2
);
   AST_LAUNCH_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cmd_valid); // R2
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data)); // R3
   AST_OFFER_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> busy); // R3
   AST_BUSY_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $rose(rvalid)); // R4
   AST_NO_LAUNCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !$rose(busy)); // R6
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !(reg_wr && reg_addr == 3'd4 && wdata_b2) |=> ovr); // R6
   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(rvalid) |-> $stable(rsp_flat)); // R7
endmodule

bind cmd_mailbox cmdmb_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .rvalid(rvalid_w), .ovr(ovr_w),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
   .rsp_flat(rsp_flat), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .wdata_b2(reg_wdata[2])
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [63:0] cmd_data;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmd_mailbox u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_raddr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic handshake();
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic respond(input logic [63:0] d);
      rsp_data = d; rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   function automatic logic [31:0] up_word(int op, int dev, logic [15:0] addr);
      return (32'(op) << 12) | (32'(dev) << 8) | 32'(addr[15:8]);
   endfunction

   function automatic logic [31:0] lo_word(logic [15:0] addr, logic [7:0] wd);
      return (32'(addr[7:0]) << 24) | (32'(wd) << 7);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(3'd4, d);
      check("R1 status after reset", 64'(d), 64'd0);
      check("R1 cmd_valid after reset", 64'(cmd_valid), 64'd0);
   endtask

   task automatic t_read_flow();
      logic [31:0] d, hi, lo;
      hi = up_word(2, 5, 16'h0123);
      lo = lo_word(16'h0123, 8'h00);
      wr(3'd0, hi);
      wr(3'd1, lo);
      check("R2 cmd_valid after launch", 64'(cmd_valid), 64'd1);
      check("R2 cmd_data packing", cmd_data, {hi, lo});
      rd(3'd4, d);
      check("R2 busy set", 64'(d), 64'd2);
      @(negedge clk); @(negedge clk);
      check("R3 valid held without ready", 64'(cmd_valid), 64'd1);
      check("R3 data held without ready", cmd_data, {hi, lo});
      wr(3'd0, 32'hDEAD_BEEF);
      check("R9 upper write in flight", cmd_data, {hi, lo});
      respond(64'h1);
      rd(3'd4, d);
      check("R10 early response ignored", 64'(d), 64'd2);
      handshake();
      check("R3 valid drops after ready", 64'(cmd_valid), 64'd0);
      respond({32'h0000_0000, (32'hA5 << 7) | 32'h1});
      rd(3'd4, d);
      check("R4 capture status", 64'(d), 64'd1);
      rd(3'd3, d);
      check("R4 lower response word", 64'(d), 64'((32'hA5 << 7) | 32'h1));
      rd(3'd2, d);
      check("R4 upper response word", 64'(d), 64'd0);
   endtask

   task automatic t_pending_drop();
      logic [31:0] d;
      wr(3'd1, 32'h1234_5678);
      check("R6 launch dropped while pending", 64'(cmd_valid), 64'd0);
      rd(3'd4, d);
      check("R6 overrun set while pending", 64'(d), 64'd5);
      wr(3'd4, 32'h0000_0002);
      rd(3'd4, d);
      check("R5 nonzero write without bit0 keeps flag", 64'(d), 64'd5);
      wr(3'd4, 32'h0000_0001);
      rd(3'd4, d);
      check("R5 W1C clears valid, R6 overrun sticky", 64'(d), 64'd4);
      rd(3'd3, d);
      check("R7 response held after clear", 64'(d), 64'((32'hA5 << 7) | 32'h1));
      wr(3'd4, 32'h0000_0004);
      rd(3'd4, d);
      check("R6 overrun cleared by bit2", 64'(d), 64'd0);
   endtask

   task automatic t_ping_zero_clear();
      logic [31:0] d;
      logic [63:0] rsp;
      rsp = {24'h0, 8'h3C, 8'h5A, 9'h0, 8'h96, 7'h01};
      wr(3'd0, 32'h0);
      cmd_ready = 1'b1;
      wr(3'd1, 32'h0);
      check("R2 ping offered", 64'(cmd_valid), 64'd1);
      check("R2 ping data", cmd_data, 64'd0);
      @(negedge clk);
      cmd_ready = 1'b0;
      respond(rsp);
      rd(3'd2, d);
      check("R4 ping upper status", 64'(d), 64'(rsp[63:32]));
      rd(3'd3, d);
      check("R4 ping lower status", 64'(d), 64'(rsp[31:0]));
      wr(3'd4, 32'h0);
      rd(3'd4, d);
      check("R5 all-zero write clears", 64'(d), 64'd0);
      respond(64'hFFFF);
      rd(3'd4, d);
      check("R10 idle response ignored", 64'(d), 64'd0);
      rd(3'd3, d);
      check("R7 idle response leaves words", 64'(d), 64'(rsp[31:0]));
   endtask

   task automatic t_busy_drop();
      logic [31:0] d, hi, lo;
      hi = up_word(3, 2, 16'h4455);
      lo = lo_word(16'h4455, 8'hC3);
      wr(3'd0, hi);
      wr(3'd1, lo);
      wr(3'd1, 32'hFFFF_FFFF);
      check("R6 busy launch keeps command", cmd_data, {hi, lo});
      rd(3'd4, d);
      check("R6 overrun set while busy", 64'(d), 64'd6);
      handshake();
      respond(64'h2);
      wr(3'd4, 32'h5);
      rd(3'd4, d);
      check("R5 R6 combined clear", 64'(d), 64'd0);
   endtask

   task automatic t_collisions();
      logic [31:0] d;
      wr(3'd1, 32'h0100_0000);
      handshake();
      rsp_data = 64'h0000_0001_0000_0081; rsp_valid = 1'b1;
      wr(3'd4, 32'h1);
      rsp_valid = 1'b0;
      rd(3'd4, d);
      check("R8 capture beats clear", 64'(d), 64'd1);
      wr(3'd4, 32'h1);
      wr(3'd1, 32'h0200_0000);
      handshake();
      rsp_data = 64'h0000_0002_0000_0101; rsp_valid = 1'b1;
      wr(3'd1, 32'h0300_0000);
      rsp_valid = 1'b0;
      check("R6 launch on capture edge dropped", 64'(cmd_valid), 64'd0);
      rd(3'd4, d);
      check("R6 overrun on capture edge", 64'(d), 64'd5);
      rd(3'd2, d);
      check("R4 response on capture edge", 64'(d), 64'd2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_flow();
      t_pending_drop();
      t_ping_zero_clear();
      t_busy_drop();
      t_collisions();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule